// File: doc/BRIEF.md
# Word Divide Unit with Generation-Selectable Condition Flags

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's complement numbers. It uses a restoring shift-subtract loop that produces one quotient bit per clock. A successful divide returns one packed 32-bit word: the quotient sits in the low half and the remainder in the high half. It also returns the four arithmetic condition flags N, Z, V and C.

A 2-bit generation selector picks one of four processor generations. The generations agree on the successful result but differ in the flags they leave behind after an overflow or a zero divisor. Some of them keep the caller's prior N and Z, so the current flags are an input.

The block is used by a sequencer. The sequencer pulses `start` with operands while the unit is idle. It then waits for the single-cycle `done` pulse and reads the result, flags, write-enable and trap request in that cycle. The trap request stands for the divide-by-zero exception, vector 5.

Top module: `wdiv_top`

## Requirements
- R1: A zero divisor ends the operation with `trap`=1 and `wr_en`=0 in the `done` cycle.
- R2: On a zero divisor, C is 0 in every generation. Generation 1 (`gen_sel`=1) returns N=1,Z=0,V=0 in unsigned mode and N=0,Z=1,V=0 in signed mode. Generations 0, 2 and 3 pass N, Z and V through from `flags_in`.
- R3: In unsigned mode, when the quotient is at most 0xFFFF, `wr_en`=1 and `result` = {remainder[15:0], quotient[15:0]}.
- R4: In signed mode, the quotient is truncated toward zero and the remainder takes the sign of the dividend. The result is packed as in R3.
- R5: On success, N = quotient bit 15, Z = (quotient[15:0]==0), and V=C=0.
- R6: Overflow is reported with `done`=1, `wr_en`=0 and `trap`=0. Unsigned mode overflows when the quotient exceeds 0xFFFF. Signed mode overflows when the true quotient lies outside -32768..32767, which covers 0x80000000 / -1.
- R7: On overflow, generation 0 (`gen_sel`=0) gives N=1, Z=0, V=1, C=0.
- R8: On overflow, generation 1 gives V=1 and C=0. In unsigned mode it also gives Z=0 and N = dividend bit 31. In signed mode it gives N=Z=0 when |dividend|>>16 >= |divisor|. Otherwise N is bit 7 of |dividend|/|divisor| and Z is set when that quotient's low byte is zero.
- R9: On overflow, generation 2 gives V=1 and C=0 and returns N and Z from `flags_in`.
- R10: On overflow, generation 3 gives N=0, Z=0, V=1, C=0.
- R11: `done` is high for exactly one cycle. It comes 1 cycle after the `start` cycle when the divisor is zero or the high half of |dividend| is >= |divisor|. Otherwise it comes 17 cycles after.
- R12: A `start` while an operation is in flight is ignored. It changes neither the running result nor its timing, and it produces no extra `done`.
- R13: After reset, `done`, `wr_en` and `trap` are low.

Flag vector order: `flags_in`/`flags_out` bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide (taken only when idle) |
| is_signed | input | 1 | 1 = two's complement operands |
| gen_sel | input | 2 | Processor generation 0..3 |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| flags_in | input | 4 | Current N,Z,V,C |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | {remainder, quotient} |
| flags_out | output | 4 | New N,Z,V,C, valid with done |
| wr_en | output | 1 | Destination write enable, valid with done |
| trap | output | 1 | Divide-by-zero trap request |

## Verification
The bench builds the unit with its default word width of 16, so the divisor is 16 bits and the dividend 32. At this width the signed edges become reachable with plain operands: the most negative dividend over -1, a quotient of exactly -32768 that fits, and +32768 that does not. The overflows detected after the loop are also reachable, and there the low byte of the magnitude quotient drives the generation 1 flags. The short 17-cycle loop lets every generation be tried against every outcome class, both early-exit and full-length, within a short run.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [1:0] {
        GEN_0 = 2'd0,
        GEN_1 = 2'd1,
        GEN_2 = 2'd2,
        GEN_3 = 2'd3
    } gen_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam int BYTE_W = 8;

    function automatic ccr_t mk_ccr(input logic n, input logic z,
                                    input logic v, input logic c);
        ccr_t r;
        r.n = n;
        r.z = z;
        r.v = v;
        r.c = c;
        return r;
    endfunction

endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep #(
    parameter int QW = 16,
    localparam int DW = 2 * QW
) (
    input  logic          is_signed,
    input  logic [DW-1:0] dividend,
    input  logic [QW-1:0] divisor,
    output logic [DW-1:0] dvd_mag,
    output logic [QW-1:0] dvs_mag,
    output logic          dvd_neg,
    output logic          quo_neg,
    output logic          zero_div,
    output logic          abs_ovf
);
    logic dvs_neg;

    always_comb begin
        dvd_neg  = is_signed & dividend[DW-1];
        dvs_neg  = is_signed & divisor[QW-1];
        dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
        dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
        quo_neg  = dvd_neg ^ dvs_neg;
        zero_div = (divisor == '0);
        abs_ovf  = (dvd_mag[DW-1:QW] >= dvs_mag);
    end

endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [QW-1:0] hi_in,
    input  logic [QW-1:0] lo_in,
    input  logic [QW-1:0] dvs_in,
    output logic [QW-1:0] quo,
    output logic [QW-1:0] rem
);
    logic [QW-1:0] part_q, shf_q, dvs_q;
    logic          loaded_q;
    logic [QW:0]   trial;
    logic          fits;
    logic [QW-1:0] diff;

    always_comb begin
        trial = {part_q, shf_q[QW-1]};
        fits  = (trial >= {1'b0, dvs_q});
        diff  = trial[QW-1:0] - dvs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q   <= '0;
            shf_q    <= '0;
            dvs_q    <= '0;
            loaded_q <= 1'b0;
        end else if (load) begin
            part_q   <= hi_in;
            shf_q    <= lo_in;
            dvs_q    <= dvs_in;
            loaded_q <= 1'b1;
        end else if (step) begin
            part_q <= fits ? diff : trial[QW-1:0];
            shf_q  <= {shf_q[QW-2:0], fits};
        end
    end

    assign quo = shf_q;
    assign rem = part_q;

    AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> (part_q < dvs_q)); // R3

endmodule

// File: rtl/wdiv_fmt.sv
module wdiv_fmt
    import wdiv_pkg::*;
#(
    parameter int QW = 16,
    localparam int DW = 2 * QW
) (
    input  gen_e          gen,
    input  logic          is_signed,
    input  logic          zdiv,
    input  logic          abs_ovf,
    input  logic          dvd_msb,
    input  logic          dvd_neg,
    input  logic          quo_neg,
    input  logic [QW-1:0] quo_mag,
    input  logic [QW-1:0] rem_mag,
    input  ccr_t          ccr_in,
    output logic [DW-1:0] result,
    output ccr_t          ccr_out,
    output logic          wr_req
);
    localparam logic [QW-1:0] HALF = {1'b1, {(QW-1){1'b0}}};

    logic [QW-1:0] quo_s, rem_s;
    logic          range_bad, ovf;

    always_comb begin
        quo_s     = quo_neg ? (~quo_mag + 1'b1) : quo_mag;
        rem_s     = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
        range_bad = quo_neg ? (quo_mag > HALF) : (quo_mag >= HALF);
        ovf       = !zdiv && (abs_ovf || (is_signed && range_bad));
        wr_req    = !zdiv && !ovf;
        result    = {rem_s, quo_s};

        if (zdiv) begin
            if (gen == GEN_1)
                ccr_out = mk_ccr(!is_signed, is_signed, 1'b0, 1'b0);
            else
                ccr_out = mk_ccr(ccr_in.n, ccr_in.z, ccr_in.v, 1'b0);
        end else if (ovf) begin
            case (gen)
                GEN_0: ccr_out = mk_ccr(1'b1, 1'b0, 1'b1, 1'b0);
                GEN_1: begin
                    if (!is_signed)
                        ccr_out = mk_ccr(dvd_msb, 1'b0, 1'b1, 1'b0);
                    else if (abs_ovf)
                        ccr_out = mk_ccr(1'b0, 1'b0, 1'b1, 1'b0);
                    else
                        ccr_out = mk_ccr(quo_mag[BYTE_W-1],
                                         quo_mag[BYTE_W-1:0] == '0, 1'b1, 1'b0);
                end
                GEN_2:   ccr_out = mk_ccr(ccr_in.n, ccr_in.z, 1'b1, 1'b0);
                default: ccr_out = mk_ccr(1'b0, 1'b0, 1'b1, 1'b0);
            endcase
        end else begin
            ccr_out = mk_ccr(quo_s[QW-1], quo_s == '0, 1'b0, 1'b0);
        end
    end

endmodule

// File: rtl/wdiv_top.sv
module wdiv_top
    import wdiv_pkg::*;
#(
    parameter int QW = 16,
    localparam int DW = 2 * QW,
    localparam int CW = $clog2(QW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          is_signed,
    input  logic [1:0]    gen_sel,
    input  logic [DW-1:0] dividend,
    input  logic [QW-1:0] divisor,
    input  logic [3:0]    flags_in,
    output logic          done,
    output logic [DW-1:0] result,
    output logic [3:0]    flags_out,
    output logic          wr_en,
    output logic          trap
);
    localparam logic [CW-1:0] LAST = CW'(QW - 1);

    state_e        state_q;
    logic [CW-1:0] cnt_q;
    logic          sgn_q, zdiv_q, absovf_q, dvdneg_q, quoneg_q, msb_q;
    gen_e          gen_q;
    ccr_t          ccr_q, ccr_w;

    logic [DW-1:0] dvd_mag_w;
    logic [QW-1:0] dvs_mag_w, quo_w, rem_w;
    logic          dvd_neg_w, quo_neg_w, zdiv_w, absovf_w;
    logic          accept, early, wr_req_w;

    wdiv_prep #(.QW(QW)) u_prep (
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .dvd_mag   (dvd_mag_w),
        .dvs_mag   (dvs_mag_w),
        .dvd_neg   (dvd_neg_w),
        .quo_neg   (quo_neg_w),
        .zero_div  (zdiv_w),
        .abs_ovf   (absovf_w)
    );

    assign accept = (state_q == ST_IDLE) && start;
    assign early  = zdiv_w || absovf_w;

    wdiv_core #(.QW(QW)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (accept && !early),
        .step   (state_q == ST_RUN),
        .hi_in  (dvd_mag_w[DW-1:QW]),
        .lo_in  (dvd_mag_w[QW-1:0]),
        .dvs_in (dvs_mag_w),
        .quo    (quo_w),
        .rem    (rem_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sgn_q    <= 1'b0;
            zdiv_q   <= 1'b0;
            absovf_q <= 1'b0;
            dvdneg_q <= 1'b0;
            quoneg_q <= 1'b0;
            msb_q    <= 1'b0;
            gen_q    <= GEN_0;
            ccr_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sgn_q    <= is_signed;
                        zdiv_q   <= zdiv_w;
                        absovf_q <= absovf_w;
                        dvdneg_q <= dvd_neg_w;
                        quoneg_q <= quo_neg_w;
                        msb_q    <= dividend[DW-1];
                        gen_q    <= gen_e'(gen_sel);
                        ccr_q    <= ccr_t'(flags_in);
                        cnt_q    <= '0;
                        state_q  <= early ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST)
                        state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    wdiv_fmt #(.QW(QW)) u_fmt (
        .gen       (gen_q),
        .is_signed (sgn_q),
        .zdiv      (zdiv_q),
        .abs_ovf   (absovf_q),
        .dvd_msb   (msb_q),
        .dvd_neg   (dvdneg_q),
        .quo_neg   (quoneg_q),
        .quo_mag   (quo_w),
        .rem_mag   (rem_w),
        .ccr_in    (ccr_q),
        .result    (result),
        .ccr_out   (ccr_w),
        .wr_req    (wr_req_w)
    );

    assign done      = (state_q == ST_FIN);
    assign wr_en     = done && wr_req_w;
    assign trap      = done && zdiv_q;
    assign flags_out = ccr_w;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (accept && (divisor == '0)) |=> (done && trap)); // R1
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        trap |-> !wr_en); // R1
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done && !trap && flags_out[1]) |-> !wr_en); // R6
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done |-> !flags_out[0]); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN)); // R12

endmodule

// File: tb/wdiv_top_tb.sv
module wdiv_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [1:0]  gen_sel = 2'd0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [3:0]  flags_in = '0;
    logic        done, wr_en, trap;
    logic [31:0] result;
    logic [3:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wdiv_top u_dut (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .gen_sel(gen_sel), .dividend(dividend), .divisor(divisor),
        .flags_in(flags_in), .done(done), .result(result),
        .flags_out(flags_out), .wr_en(wr_en), .trap(trap)
    );

    // {signed, gen, dividend, divisor, flags_in}
    localparam int NV = 24;
    localparam logic [54:0] VEC [NV] = '{
        {1'b0, 2'd0, 32'd100,        16'd7,      4'h0},   // R3
        {1'b0, 2'd3, 32'h0001_0000,  16'h0002,   4'hF},   // R3 R5 N set
        {1'b0, 2'd2, 32'h0000_FFFE,  16'hFFFF,   4'h0},   // R5 Z set
        {1'b0, 2'd1, 32'hFFFE_0001,  16'hFFFF,   4'h0},   // R3 max quotient
        {1'b0, 2'd0, 32'hFFFF_FFFF,  16'hFFFF,   4'h0},   // R7
        {1'b0, 2'd1, 32'h8000_0000,  16'h0002,   4'h0},   // R8 N=msb
        {1'b0, 2'd1, 32'h0001_0000,  16'h0001,   4'h0},   // R8 msb 0
        {1'b0, 2'd2, 32'h0001_0000,  16'h0001,   4'hC},   // R9
        {1'b0, 2'd3, 32'h0001_0000,  16'h0001,   4'hC},   // R10
        {1'b1, 2'd0, -32'sd7,        16'd2,      4'h0},   // R4
        {1'b1, 2'd3, 32'd7,          -16'sd2,    4'h0},   // R4
        {1'b1, 2'd2, -32'sd100,      -16'sd7,    4'h0},   // R4
        {1'b1, 2'd0, 32'hFFF8_0000,  16'd16,     4'h0},   // R4 -32768 fits
        {1'b1, 2'd0, 32'h8000_0000,  16'hFFFF,   4'h0},   // R6 R7
        {1'b1, 2'd1, 32'h8000_0000,  16'hFFFF,   4'h0},   // R8 absolute
        {1'b1, 2'd2, 32'h8000_0000,  16'hFFFF,   4'h8},   // R9
        {1'b1, 2'd3, 32'h8000_0000,  16'hFFFF,   4'hC},   // R10
        {1'b1, 2'd1, 32'h0010_0000,  16'd17,     4'h0},   // R8 late, byte N
        {1'b1, 2'd1, 32'h0010_0000,  16'd32,     4'h0},   // R8 late, byte Z
        {1'b1, 2'd3, 32'h0008_0000,  16'd16,     4'hF},   // R6 +32768
        {1'b0, 2'd1, 32'h1234_5678,  16'h0000,   4'hF},   // R1 R2
        {1'b1, 2'd1, 32'h1234_5678,  16'h0000,   4'hF},   // R2
        {1'b0, 2'd2, 32'h0000_0005,  16'h0000,   4'hA},   // R2
        {1'b1, 2'd0, 32'h0000_0005,  16'h0000,   4'h4}    // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input bit sgn, input bit [1:0] vr, input bit [31:0] dvd,
                         input bit [15:0] dvs, input bit [3:0] fin,
                         output bit e_trap, output bit e_wr, output bit [3:0] e_fl,
                         output bit [31:0] e_res, output int e_lat);
        longint a, b, q, r, aa, ab, aq;
        bit ovf, absovf;
        e_res = '0;
        if (dvs == 0) begin
            e_trap = 1; e_wr = 0; e_lat = 1;
            e_fl = (vr == 2'd1) ? {~sgn, sgn, 2'b00} : {fin[3:1], 1'b0};
            return;
        end
        e_trap = 0;
        if (sgn) begin
            a = longint'($signed(dvd)); b = longint'($signed(dvs));
        end else begin
            a = longint'(dvd); b = longint'(dvs);
        end
        aa = (a < 0) ? -a : a;
        ab = (b < 0) ? -b : b;
        absovf = ((aa >>> 16) >= ab);
        q = a / b;
        r = a % b;
        ovf = sgn ? (q > 32767 || q < -32768) : (q > 65535);
        e_lat = absovf ? 1 : 17;
        if (!ovf) begin
            e_wr = 1;
            e_res = {r[15:0], q[15:0]};
            e_fl = {q[15], q[15:0] == 16'h0, 2'b00};
        end else begin
            e_wr = 0;
            case (vr)
                2'd0: e_fl = 4'b1010;
                2'd1: begin
                    if (!sgn) e_fl = {dvd[31], 3'b010};
                    else if (absovf) e_fl = 4'b0010;
                    else begin
                        aq = aa / ab;
                        e_fl = {aq[7], aq[7:0] == 8'h0, 2'b10};
                    end
                end
                2'd2: e_fl = {fin[3:2], 2'b10};
                default: e_fl = 4'b0010;
            endcase
        end
    endtask

    task automatic run_op(input bit sgn, input bit [1:0] vr, input bit [31:0] dvd,
                          input bit [15:0] dvs, input bit [3:0] fin);
        bit e_trap, e_wr;
        bit [3:0] e_fl;
        bit [31:0] e_res;
        int e_lat, lat;
        string fr;
        model(sgn, vr, dvd, dvs, fin, e_trap, e_wr, e_fl, e_res, e_lat);
        @(negedge clk);
        is_signed = sgn; gen_sel = vr; dividend = dvd; divisor = dvs; flags_in = fin;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R11 latency", lat, e_lat);
        check("R1 trap", trap, e_trap);
        check(e_trap ? "R1 wr_en" : "R6 wr_en", wr_en, e_wr);
        if (e_trap) fr = "R2 flags";
        else if (e_wr) fr = "R5 flags";
        else case (vr)
            2'd0: fr = "R7 flags";
            2'd1: fr = "R8 flags";
            2'd2: fr = "R9 flags";
            default: fr = "R10 flags";
        endcase
        check(fr, flags_out, e_fl);
        if (e_wr) check(sgn ? "R4 result" : "R3 result", result, e_res);
        @(negedge clk);
        check("R11 done pulse", done, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int lat;
        int extra;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R13 done", done, 1'b0);
        check("R13 wr_en", wr_en, 1'b0);
        check("R13 trap", trap, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_op(VEC[i][54], VEC[i][53:52], VEC[i][51:20], VEC[i][19:4], VEC[i][3:0]);

        // R12: second start during a run is ignored
        @(negedge clk);
        is_signed = 1'b0; gen_sel = 2'd0; dividend = 32'd1000; divisor = 16'd3; flags_in = 4'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (2) begin @(negedge clk); lat++; end
        dividend = 32'h0000_0009; divisor = 16'h0000; is_signed = 1'b1; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check("R12 latency", lat, 17);
        check("R12 result", result, {16'd1, 16'd333});
        check("R12 trap", trap, 1'b0);
        check("R12 wr_en", wr_en, 1'b1);
        extra = 0;
        repeat (20) begin @(negedge clk); if (done) extra++; end
        check("R12 no extra done", extra, 0);

        // R13: reset mid-run clears outputs
        @(negedge clk);
        dividend = 32'd50; divisor = 16'd5; is_signed = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        extra = 0;
        repeat (20) begin @(negedge clk); if (done || wr_en || trap) extra++; end
        check("R13 quiet after reset", extra, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule